// File: doc/BRIEF.md
# Level-Sensitive Dual-Output Interrupt Controller

This block gathers up to 32 level-sensitive interrupt requests and presents them to a processor as two outputs: a normal interrupt (IRQ) and a fast interrupt (FIQ). Each external request first passes through a two-flop synchroniser. It is then ORed with a software-generated request bit to form a raw pending vector. Two independent enable registers gate that vector: one feeds the IRQ output and one feeds the FIQ output. The same line may drive either output, or both.

Software reaches the block through a small register bus with one address, a write strobe and data, and a read strobe and data. Every enable and soft-request register has a pair of addresses: writing ones to the "set" address turns bits on, and writing ones to the "clear" address turns them off. A handler reads the masked status, services the lines it finds, and acknowledges a line by masking it or by removing its source. A build-time mask marks which bit positions are wired. Positions that are not wired stay at zero in every register.

Top module: `lvl_intc`

## Requirements
- R1: After reset, the IRQ enable, FIQ enable and soft-request registers read zero, and `irq_out` and `fiq_out` are low.
- R2: A write to 0x08 sets every IRQ enable bit whose data bit is one. A write to 0x0C clears every IRQ enable bit whose data bit is one. Data bits that are zero leave their enables unchanged. A read of either address returns the IRQ enable register.
- R3: A write to 0x10 sets soft-request bits and a write to 0x14 clears them, with the same write-one behaviour. A read of either address returns the soft-request register. Soft bits are ORed into the raw vector.
- R4: Reading 0x04 or 0x24 returns the raw vector: synchronised requests OR soft bits, whatever the enables hold.
- R5: Reading 0x00 returns the raw vector ANDed with the IRQ enables. `irq_out` is high exactly when that value is non-zero.
- R6: Reading 0x20 returns the raw vector ANDed with the FIQ enables, and `fiq_out` is its OR. FIQ enables are set at 0x28 and cleared at 0x2C, read back at either address, and never change the IRQ enables.
- R7: A status bit stays set for as long as its request is held. It clears only when its enable is cleared or its request drops.
- R8: Bit positions that are zero in parameter `VALID` never become enabled, never hold a soft bit and never appear in raw or masked status.
- R9: A change on `req_in` sampled at one rising edge is not visible at the outputs after that edge, and is visible after the following edge.
- R10: Read data is registered: `rdata` shows the addressed register on the cycle after `rd_en`. Addresses that are not mapped read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | NLINES | Asynchronous level-sensitive requests |
| addr | input | AW | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wdata | input | NLINES | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | NLINES | Registered read data |
| irq_out | output | 1 | Normal interrupt to the processor |
| fiq_out | output | 1 | Fast interrupt to the processor |

## Verification
The bench builds the block with `VALID` = 32'h7FFF_FFF7, leaving bits 3 and 31 unwired and all other parameters at their defaults. With that value, all-ones writes to the enable and soft addresses, and requests driven on the two missing lines, show directly at the read port whether those positions stay at zero. The default 32-bit width and two synchroniser stages let the bench count edges from a request change to the output.

// File: rtl/lvl_intc.sv
module lvl_intc #(
  parameter int NLINES = 32,
  parameter logic [NLINES-1:0] VALID = '1,
  parameter int SYNC_STAGES = 2,
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] req_in,
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic [NLINES-1:0] wdata,
  input  logic              rd_en,
  output logic [NLINES-1:0] rdata,
  output logic              irq_out,
  output logic              fiq_out
);

  localparam logic [AW-1:0] A_IRQ_STAT = AW'('h00);
  localparam logic [AW-1:0] A_IRQ_RAW  = AW'('h04);
  localparam logic [AW-1:0] A_IRQ_SET  = AW'('h08);
  localparam logic [AW-1:0] A_IRQ_CLR  = AW'('h0C);
  localparam logic [AW-1:0] A_SW_SET   = AW'('h10);
  localparam logic [AW-1:0] A_SW_CLR   = AW'('h14);
  localparam logic [AW-1:0] A_FIQ_STAT = AW'('h20);
  localparam logic [AW-1:0] A_FIQ_RAW  = AW'('h24);
  localparam logic [AW-1:0] A_FIQ_SET  = AW'('h28);
  localparam logic [AW-1:0] A_FIQ_CLR  = AW'('h2C);

  logic [SYNC_STAGES-1:0][NLINES-1:0] sync_q;
  logic [NLINES-1:0] irq_en, fiq_en, soft_q;
  logic [NLINES-1:0] ext, raw, irq_stat, fiq_stat, rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], req_in};
  end

  assign ext      = sync_q[SYNC_STAGES-1] & VALID;
  assign raw      = ext | soft_q;
  assign irq_stat = raw & irq_en;
  assign fiq_stat = raw & fiq_en;
  assign irq_out  = |irq_stat;
  assign fiq_out  = |fiq_stat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= '0;
      fiq_en <= '0;
      soft_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_IRQ_SET: irq_en <= irq_en | (wdata & VALID);
        A_IRQ_CLR: irq_en <= irq_en & ~wdata;
        A_SW_SET:  soft_q <= soft_q | (wdata & VALID);
        A_SW_CLR:  soft_q <= soft_q & ~wdata;
        A_FIQ_SET: fiq_en <= fiq_en | (wdata & VALID);
        A_FIQ_CLR: fiq_en <= fiq_en & ~wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_IRQ_STAT:           rd_mux = irq_stat;
      A_IRQ_RAW, A_FIQ_RAW: rd_mux = raw;
      A_IRQ_SET, A_IRQ_CLR: rd_mux = irq_en;
      A_SW_SET, A_SW_CLR:   rd_mux = soft_q;
      A_FIQ_STAT:           rd_mux = fiq_stat;
      A_FIQ_SET, A_FIQ_CLR: rd_mux = fiq_en;
      default:              rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // assertion support: edges seen since reset, saturating
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_IRQ_SET) |=> ((irq_en & $past(wdata) & VALID) == ($past(wdata) & VALID)));
  p_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_IRQ_CLR) |=> ((irq_en & $past(wdata)) == '0));
  p_soft_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SW_CLR) |=> ((soft_q & $past(wdata)) == '0));
  p_stat_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_IRQ_STAT && irq_out) |=> (rdata != '0));
  p_fiq_indep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_FIQ_SET || addr == A_FIQ_CLR)) |=> $stable(irq_en));
  p_unwired_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_en | fiq_en | soft_q | raw) & ~VALID) == '0);
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'('h18)) |=> (rdata == '0));

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      p_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (ext == ($past(req_in, 2) & VALID)));
    end
  endgenerate

endmodule

// File: tb/lvl_intc_test.sv
module lvl_intc_test;
  localparam int NL = 32;
  localparam logic [NL-1:0] VMASK = 32'h7FFF_FFF7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] req_in = '0;
  logic [5:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [NL-1:0] wdata = '0;
  logic [NL-1:0] rdata;
  logic irq_out, fiq_out;

  always #10 clk = ~clk;

  lvl_intc #(.NLINES(NL), .VALID(VMASK)) uut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq_out(irq_out), .fiq_out(fiq_out));

  int checks = 0, fails = 0;

  // op: 0 write, 1 read+check, 2 drive requests ; {op, addr, data, expected, irq, fiq, tag}
  localparam int NV = 29;
  localparam logic [81:0] VECS [NV] = '{
    {2'd1, 6'h08, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 8'd1},  // R1
    {2'd1, 6'h10, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 8'd1},  // R1
    {2'd0, 6'h08, 32'h0000_00FF, 32'h0, 1'b0, 1'b0, 8'd2},
    {2'd1, 6'h08, 32'h0, 32'h0000_00F7, 1'b0, 1'b0, 8'd8},  // R8 bit3 unwired
    {2'd0, 6'h0C, 32'h0000_000F, 32'h0, 1'b0, 1'b0, 8'd2},
    {2'd1, 6'h0C, 32'h0, 32'h0000_00F0, 1'b0, 1'b0, 8'd2},  // R2
    {2'd2, 6'h00, 32'h0000_0021, 32'h0, 1'b0, 1'b0, 8'd4},
    {2'd1, 6'h04, 32'h0, 32'h0000_0021, 1'b1, 1'b0, 8'd4},  // R4
    {2'd1, 6'h00, 32'h0, 32'h0000_0020, 1'b1, 1'b0, 8'd5},  // R5
    {2'd0, 6'h28, 32'h0000_0001, 32'h0, 1'b0, 1'b0, 8'd6},
    {2'd1, 6'h20, 32'h0, 32'h0000_0001, 1'b1, 1'b1, 8'd6},  // R6
    {2'd1, 6'h28, 32'h0, 32'h0000_0001, 1'b1, 1'b1, 8'd6},  // R6
    {2'd1, 6'h08, 32'h0, 32'h0000_00F0, 1'b1, 1'b1, 8'd6},  // R6 irq enables untouched
    {2'd0, 6'h10, 32'h8000_0108, 32'h0, 1'b0, 1'b0, 8'd3},
    {2'd1, 6'h10, 32'h0, 32'h0000_0100, 1'b1, 1'b1, 8'd3},  // R3
    {2'd1, 6'h24, 32'h0, 32'h0000_0121, 1'b1, 1'b1, 8'd3},  // R3
    {2'd0, 6'h08, 32'h0000_0100, 32'h0, 1'b0, 1'b0, 8'd2},
    {2'd1, 6'h00, 32'h0, 32'h0000_0120, 1'b1, 1'b1, 8'd5},  // R5
    {2'd0, 6'h14, 32'h0000_0100, 32'h0, 1'b0, 1'b0, 8'd3},
    {2'd1, 6'h04, 32'h0, 32'h0000_0021, 1'b1, 1'b1, 8'd3},  // R3
    {2'd0, 6'h0C, 32'h0000_0020, 32'h0, 1'b0, 1'b0, 8'd7},
    {2'd1, 6'h00, 32'h0, 32'h0000_0000, 1'b0, 1'b1, 8'd7},  // R7 masked
    {2'd1, 6'h18, 32'h0, 32'h0000_0000, 1'b0, 1'b1, 8'd10}, // R10 unmapped
    {2'd0, 6'h2C, 32'h0000_0001, 32'h0, 1'b0, 1'b0, 8'd6},
    {2'd1, 6'h20, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 8'd6},  // R6
    {2'd2, 6'h00, 32'h8000_0008, 32'h0, 1'b0, 1'b0, 8'd8},
    {2'd1, 6'h04, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 8'd8},  // R8
    {2'd0, 6'h08, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 8'd8},
    {2'd1, 6'h08, 32'h0, 32'h7FFF_FFF7, 1'b0, 1'b0, 8'd8}   // R8
  };

  task automatic check(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [NL-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [5:0] a, output logic [NL-1:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic drive_req(input logic [NL-1:0] r);
    @(negedge clk); req_in = r;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [NL-1:0] rd;
    repeat (3) @(negedge clk);
    check("R1 irq_out after reset", NL'(irq_out), '0);
    check("R1 fiq_out after reset", NL'(fiq_out), '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [81:0] v;
      string tg;
      v = VECS[i];
      tg = $sformatf("R%0d vector %0d", v[7:0], i);
      case (v[81:80])
        2'd0: do_write(v[79:74], v[73:42]);
        2'd2: drive_req(v[73:42]);
        default: begin
          do_read(v[79:74], rd);
          check(tg, rd, v[41:10]);
          check({tg, " irq_out"}, NL'(irq_out), NL'(v[9]));
          check({tg, " fiq_out"}, NL'(fiq_out), NL'(v[8]));
        end
      endcase
    end

    // R9: two edges from request to output (all wired enables are on)
    @(negedge clk); req_in = 32'h0000_0400;
    @(negedge clk); check("R9 one edge after request", NL'(irq_out), '0);
    @(negedge clk); check("R9 two edges after request", NL'(irq_out), 32'h1);

    // R7: held request stays pending across reads
    do_read(6'h00, rd); check("R7 status while held", rd, 32'h0000_0400);
    repeat (5) @(negedge clk);
    do_read(6'h00, rd); check("R7 status still held", rd, 32'h0000_0400);
    drive_req('0);
    check("R7 request dropped", NL'(irq_out), '0);

    // R7: mask acknowledge while held; raw remains
    drive_req(32'h0000_0400);
    do_write(6'h0C, 32'h0000_0400);
    check("R7 masked irq_out", NL'(irq_out), '0);
    do_read(6'h04, rd); check("R7 raw still set", rd, 32'h0000_0400);

    // R1: reset in mid-run
    do_write(6'h28, 32'h0000_0400);
    do_write(6'h10, 32'h0000_0002);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 irq_out in reset", NL'(irq_out), '0);
    check("R1 fiq_out in reset", NL'(fiq_out), '0);
    rst_n = 1'b1;
    do_read(6'h28, rd); check("R1 fiq enables after reset", rd, '0);
    do_read(6'h14, rd); check("R1 soft bits after reset", rd, '0);
    do_read(6'h0C, rd); check("R1 irq enables after reset", rd, '0);
    do_read(6'h24, rd); check("R4 raw after reset", rd, 32'h0000_0400);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule